// File: doc/BRIEF.md
# Serial Register Access Front End

This block is a serial-peripheral-bus slave that lets an external master read and write a 32-entry byte register file. Each select window opens with a command byte carrying a register number, a direction bit and an acknowledge flag. Any number of data bytes follow in the same window. After each data byte the internal register pointer either holds or moves forward, depending on which range of registers it points at. Holding on the low registers lets a queue-style register be streamed byte after byte. Moving forward elsewhere lets a block of control registers be written or read in one burst.

Two wiring options exist. In full-duplex mode a status byte taken from the status input is shifted out on the data-out line while the command byte is shifted in. In half-duplex mode the data-out line is never driven, and read data is driven back on the data-in line, which then carries traffic both ways. The serial pins are brought into the system clock domain through a synchronizer and sampled there. All register updates and line changes happen on the system clock.

The control state machine has three states. IDLE waits while select is high and moves to CMD once select is seen low. CMD gathers the command byte and moves to DATA after its eighth bit. DATA handles data bytes until select goes high. From CMD or DATA, select going high returns the machine to IDLE.

Top module: `spi_reg_frontend`

## Requirements
- R1: Command byte layout, sent most significant bit first: bits 7..3 give the register number, bit 2 is zero, bit 1 gives the direction (1 = write, 0 = read), and bit 0 is the acknowledge flag. A written byte reads back unchanged.
- R2: Input bits are taken on the rising edge of the serial clock. Output bits change after the falling edge. Both directions send the most significant bit first.
- R3: While select is high, serial clock edges have no effect and both line enables are low. While select is low in full-duplex mode, the data-out enable is high.
- R4: For registers 0 to 4 the pointer holds after each data byte. Two bytes written to register 2 leave the second byte in register 2, and register 3 is unchanged.
- R5: For registers 5 to 19 the pointer moves up by one after each data byte, for both reads and writes.
- R6: Register 20 holds the pointer. A burst starting at 19 fills 19 and then keeps overwriting 20, and register 21 is untouched.
- R7: Registers 21 to 30 move the pointer up. Register 31 holds it, so a burst never wraps to register 0.
- R8: In full-duplex mode the byte on the status input, captured when select goes low, comes out on the data-out line during the command byte.
- R9: In half-duplex mode the data-out enable stays low. During the data bytes of a read, read data is driven on the data-in line with its enable high.
- R10: A command byte with the acknowledge flag set makes bit 0 of register 9 become 1 when the host-mode input is 0. When the host-mode input is 1, the flag has no effect.
- R11: If select goes high before the eighth bit of a data byte, the partial byte is dropped and no register changes.
- R12: After reset every register reads as zero and neither line enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master, idle low |
| ss_n_i | input | 1 | Select, active low |
| mosi_i | input | 1 | Data-in line, as seen at the pad |
| half_duplex_i | input | 1 | 1 selects the shared-line wiring |
| host_mode_i | input | 1 | 1 makes the acknowledge flag have no effect |
| status_i | input | 8 | Status byte returned during the command byte |
| miso_o | output | 1 | Data-out line value |
| miso_oe_o | output | 1 | Data-out line drive enable |
| mosi_o | output | 1 | Value driven onto the shared data-in line |
| mosi_oe_o | output | 1 | Drive enable for the shared data-in line |

## Verification
The synchronizer has two stages, and one more register is used for edge detection. Each line change that follows a falling serial clock edge, and each line enable that follows select, therefore shows up within three system clocks. Register writes and pointer steps land in the same window after the eighth rising edge. The bench holds each serial clock phase for six system clocks and samples the returned line just before it raises the serial clock, so every result is read well after it settles. It reads register contents back only through later read transfers, which start more than twenty system clocks after the write that set them.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2
    } fe_state_t;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    localparam int CHAIN_W = WIDTH * STAGES;

    logic [CHAIN_W-1:0] chain_q;
    logic [WIDTH-1:0]   prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
            prev_q  <= RST_VAL;
        end else begin
            chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], pin_i};
            prev_q  <= chain_q[CHAIN_W-1 -: WIDTH];
        end
    end

    assign sync_o = chain_q[CHAIN_W-1 -: WIDTH];
    assign prev_o = prev_q;
endmodule

// File: rtl/spi_addr_step.sv
module spi_addr_step #(
    parameter int AW        = 5,
    parameter int FIFO_LAST = 4,
    parameter int MID_HOLD  = 20
) (
    input  logic [AW-1:0] cur_i,
    output logic [AW-1:0] nxt_o
);
    localparam logic [AW-1:0] FIFO_TOP = AW'(FIFO_LAST);
    localparam logic [AW-1:0] MID_REG  = AW'(MID_HOLD);
    localparam logic [AW-1:0] LAST_REG = {AW{1'b1}};

    logic hold;

    always_comb begin
        hold  = (cur_i <= FIFO_TOP) || (cur_i == MID_REG) || (cur_i == LAST_REG);
        nxt_o = hold ? cur_i : cur_i + AW'(1);
    end
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file #(
    parameter int NREG    = 32,
    parameter int DW      = 8,
    parameter int ACK_REG = 9,
    parameter int ACK_BIT = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [$clog2(NREG)-1:0] wr_addr_i,
    input  logic [DW-1:0]           wr_data_i,
    input  logic                    ack_set_i,
    input  logic [$clog2(NREG)-1:0] rd_addr_i,
    output logic [DW-1:0]           rd_data_o
);
    localparam int AW = $clog2(NREG);
    localparam logic [AW-1:0] ACK_IDX = AW'(ACK_REG);

    logic [NREG-1:0][DW-1:0] mem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (wr_en_i && (wr_addr_i == AW'(i))) begin
                    mem_q[i] <= wr_data_i;
                end else if (ack_set_i && (i == ACK_REG)) begin
                    mem_q[i][ACK_BIT] <= 1'b1;
                end
            end
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

    // R10: an acknowledge request leaves the flag bit set
    p_ack_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_set_i && !(wr_en_i && wr_addr_i == ACK_IDX)) |=> mem_q[ACK_REG][ACK_BIT]);
endmodule

// File: rtl/spi_reg_frontend.sv
module spi_reg_frontend #(
    parameter int NREG        = 32,
    parameter int SYNC_STAGES = 2,
    parameter int FIFO_LAST   = 4,
    parameter int MID_HOLD    = 20,
    parameter int ACK_REG     = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_i,
    input  logic       ss_n_i,
    input  logic       mosi_i,
    input  logic       half_duplex_i,
    input  logic       host_mode_i,
    input  logic [7:0] status_i,
    output logic       miso_o,
    output logic       miso_oe_o,
    output logic       mosi_o,
    output logic       mosi_oe_o
);
    import spi_rf_pkg::*;

    localparam int AW = $clog2(NREG);
    localparam int BW = $clog2(BYTE_W);
    localparam logic [BW-1:0]  LAST_BIT = BW'(BYTE_W - 1);
    localparam logic [AW-1:0]  FIFO_TOP = AW'(FIFO_LAST);
    localparam logic [AW-1:0]  MID_REG  = AW'(MID_HOLD);
    localparam logic [AW-1:0]  LAST_REG = {AW{1'b1}};

    // synchronized pins: {mosi, ss_n, sclk}
    logic [2:0] pins_s, pins_p;
    logic sclk_s, sclk_p, ss_s, mosi_s;
    logic sclk_rise, sclk_fall;
    logic unused_prev;

    spi_pin_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({mosi_i, ss_n_i, sclk_i}),
        .sync_o(pins_s),
        .prev_o(pins_p)
    );

    assign sclk_s      = pins_s[0];
    assign ss_s        = pins_s[1];
    assign mosi_s      = pins_s[2];
    assign sclk_p      = pins_p[0];
    assign unused_prev = pins_p[1] ^ pins_p[2];
    assign sclk_rise   = sclk_s & ~sclk_p;
    assign sclk_fall   = ~sclk_s & sclk_p;

    fe_state_t state_q, state_d;

    logic [BW-1:0]     bit_q;
    logic [BYTE_W-1:0] rx_q, rx_byte;
    logic [BYTE_W-1:0] tx_q, tx_next_q;
    logic              load_pend_q;
    logic [AW-1:0]     addr_q, addr_nxt, rd_addr;
    logic              dir_q;
    logic              byte_end;
    logic              wr_en, ack_set;
    logic [BYTE_W-1:0] rd_data;
    logic              unused_zero_bit;

    assign rx_byte         = {rx_q[BYTE_W-2:0], mosi_s};
    assign unused_zero_bit = rx_byte[2];
    assign byte_end        = sclk_rise && (bit_q == LAST_BIT) && !ss_s;
    assign wr_en           = byte_end && (state_q == ST_DATA) && dir_q;
    assign ack_set         = byte_end && (state_q == ST_CMD) && rx_byte[0] && !host_mode_i;
    assign rd_addr         = (state_q == ST_CMD) ? rx_byte[BYTE_W-1 -: AW] : addr_nxt;

    spi_addr_step #(
        .AW       (AW),
        .FIFO_LAST(FIFO_LAST),
        .MID_HOLD (MID_HOLD)
    ) u_step (
        .cur_i(addr_q),
        .nxt_o(addr_nxt)
    );

    spi_reg_file #(
        .NREG   (NREG),
        .DW     (BYTE_W),
        .ACK_REG(ACK_REG),
        .ACK_BIT(0)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_addr_i(addr_q),
        .wr_data_i(rx_byte),
        .ack_set_i(ack_set),
        .rd_addr_i(rd_addr),
        .rd_data_o(rd_data)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (!ss_s) state_d = ST_CMD;
            ST_CMD: begin
                if (ss_s)          state_d = ST_IDLE;
                else if (byte_end) state_d = ST_DATA;
            end
            ST_DATA: if (ss_s) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shift and pointer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q       <= '0;
            rx_q        <= '0;
            tx_q        <= '0;
            tx_next_q   <= '0;
            load_pend_q <= 1'b0;
            addr_q      <= '0;
            dir_q       <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            bit_q       <= '0;
            load_pend_q <= 1'b0;
            if (!ss_s) tx_q <= status_i;
        end else if (!ss_s) begin
            if (sclk_rise) begin
                rx_q  <= rx_byte;
                bit_q <= bit_q + BW'(1);
                if (bit_q == LAST_BIT) begin
                    load_pend_q <= 1'b1;
                    tx_next_q   <= rd_data;
                    if (state_q == ST_CMD) begin
                        addr_q <= rx_byte[BYTE_W-1 -: AW];
                        dir_q  <= rx_byte[1];
                    end else begin
                        addr_q <= addr_nxt;
                    end
                end
            end
            if (sclk_fall) begin
                if (load_pend_q) begin
                    tx_q        <= tx_next_q;
                    load_pend_q <= 1'b0;
                end else begin
                    tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    // line outputs
    always_comb begin
        miso_oe_o = (state_q != ST_IDLE) && !half_duplex_i;
        miso_o    = miso_oe_o ? tx_q[BYTE_W-1] : 1'b0;
        mosi_oe_o = (state_q == ST_DATA) && !dir_q && half_duplex_i;
        mosi_o    = mosi_oe_o ? tx_q[BYTE_W-1] : 1'b0;
    end

    // R3: two cycles of select high means nothing is driven
    p_hiz_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ss_s) && ss_s) |-> (!miso_oe_o && !mosi_oe_o));

    // R4: queue registers keep the pointer
    p_fifo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && byte_end && addr_q <= FIFO_TOP) |=> (addr_q == $past(addr_q)));

    // R5: middle range steps by one
    p_mid_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && byte_end && addr_q > FIFO_TOP && addr_q < MID_REG)
        |=> (addr_q == $past(addr_q) + AW'(1)));

    // R7: last register never wraps
    p_top_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && byte_end && addr_q == LAST_REG) |=> (addr_q == LAST_REG));
endmodule

// File: tb/tb_spi_reg_frontend.sv
module tb_spi_reg_frontend;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic ss_n = 1'b1;
    logic mosi_drv = 1'b0;
    logic half_mode = 1'b0;
    logic host_mode = 1'b0;
    logic [7:0] status_val = 8'h96;
    logic miso_o, miso_oe, mosi_o, mosi_oe;
    logic mosi_line;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    assign mosi_line = mosi_oe ? mosi_o : mosi_drv;

    spi_reg_frontend dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_i       (sclk),
        .ss_n_i       (ss_n),
        .mosi_i       (mosi_line),
        .half_duplex_i(half_mode),
        .host_mode_i  (host_mode),
        .status_i     (status_val),
        .miso_o       (miso_o),
        .miso_oe_o    (miso_oe),
        .mosi_o       (mosi_o),
        .mosi_oe_o    (mosi_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops returned bytes and compares with the expected queue
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0 && exp_q.size() > 0) begin
                chk(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
            end
        end
    end

    task automatic shift_bits(input logic [7:0] dout, input int nbits, output logic [7:0] din);
        din = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi_drv = dout[i];
            tick(HALF);
            din[i] = half_mode ? mosi_line : miso_o;
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic sel();
        ss_n = 1'b0;
        tick(HALF);
    endtask

    task automatic desel();
        tick(HALF);
        ss_n = 1'b1;
        tick(4 * HALF);
    endtask

    task automatic send_cmd(input logic [4:0] r, input logic dir, input logic ack);
        logic [7:0] st;
        shift_bits({r, 1'b0, dir, ack}, 8, st);
        if (!half_mode) begin
            exp_q.push_back(status_val);
            tag_q.push_back("R8 status byte");
            got_q.push_back(st);
        end
    endtask

    task automatic wr(input logic [4:0] r, input int n, input logic [23:0] d, input logic ack);
        logic [7:0] dummy;
        sel();
        send_cmd(r, 1'b1, ack);
        for (int k = 0; k < n; k++) shift_bits(d[23-8*k -: 8], 8, dummy);
        desel();
    endtask

    task automatic rd(input logic [4:0] r, input int n, input logic [23:0] e,
                      input string tag, input logic ack);
        logic [7:0] got;
        sel();
        send_cmd(r, 1'b0, ack);
        if (half_mode) begin
            chk("R9 shared line enable", {7'b0, mosi_oe}, 8'h01);
            chk("R9 data-out enable low", {7'b0, miso_oe}, 8'h00);
        end
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(e[23-8*k -: 8]);
            tag_q.push_back(tag);
            shift_bits(8'h00, 8, got);
            got_q.push_back(got);
        end
        desel();
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] dummy;
        tick(5);
        // R12: no drive during reset
        chk("R12 miso enable in reset", {7'b0, miso_oe}, 8'h00);
        chk("R12 mosi enable in reset", {7'b0, mosi_oe}, 8'h00);
        rst_n = 1'b1;
        tick(5);
        rd(5'd5, 1, 24'h000000, "R12 register zero after reset", 1'b0);
        rd(5'd31, 1, 24'h000000, "R12 last register zero after reset", 1'b0);

        // R1 / R2: write and read back, two patterns
        wr(5'd12, 1, 24'hA50000, 1'b0);
        rd(5'd12, 1, 24'hA50000, "R1 readback A5", 1'b0);
        wr(5'd12, 1, 24'h3C0000, 1'b0);
        status_val = 8'h3B;
        rd(5'd12, 1, 24'h3C0000, "R2 readback 3C", 1'b0);

        // R3 / R8: enable follows select
        sel();
        chk("R3 data-out enabled while selected", {7'b0, miso_oe}, 8'h01);
        send_cmd(5'd12, 1'b0, 1'b0);
        shift_bits(8'h00, 8, dummy);
        desel();
        chk("R3 data-out released after select", {7'b0, miso_oe}, 8'h00);

        // R3: clock toggling while deselected changes nothing
        for (int i = 0; i < 10; i++) begin
            mosi_drv = i[0];
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
            tick(HALF);
            chk("R3 no drive while deselected", {7'b0, miso_oe}, 8'h00);
        end
        rd(5'd12, 1, 24'h3C0000, "R3 register unchanged by idle clocks", 1'b0);

        // R4: queue register holds
        wr(5'd2, 2, 24'h112200, 1'b0);
        rd(5'd2, 1, 24'h220000, "R4 register 2 holds last byte", 1'b0);
        rd(5'd3, 1, 24'h000000, "R4 register 3 untouched", 1'b0);

        // R5: middle range increments
        wr(5'd7, 2, 24'h717200, 1'b0);
        rd(5'd7, 2, 24'h717200, "R5 burst read 7 and 8", 1'b0);
        rd(5'd8, 1, 24'h720000, "R5 register 8", 1'b0);

        // R6: register 20 holds
        wr(5'd19, 3, 24'hA1A2A3, 1'b0);
        rd(5'd19, 3, 24'hA1A3A3, "R6 burst 19 then 20 held", 1'b0);
        rd(5'd21, 1, 24'h000000, "R6 register 21 untouched", 1'b0);

        // R7: upper range increments, 31 holds
        wr(5'd30, 3, 24'hB1B2B3, 1'b0);
        rd(5'd30, 2, 24'hB1B300, "R7 registers 30 and 31", 1'b0);
        rd(5'd0, 1, 24'h000000, "R7 no wrap to register 0", 1'b0);

        // R10: acknowledge flag in peripheral mode, ignored in host mode
        rd(5'd9, 1, 24'h000000, "R10 flag clear before ack", 1'b1);
        rd(5'd9, 1, 24'h010000, "R10 flag set by ack", 1'b0);
        wr(5'd9, 1, 24'h000000, 1'b0);
        host_mode = 1'b1;
        rd(5'd9, 1, 24'h000000, "R10 ack in host mode", 1'b1);
        rd(5'd9, 1, 24'h000000, "R10 flag stays clear in host mode", 1'b0);
        host_mode = 1'b0;

        // R11: partial byte dropped
        wr(5'd13, 1, 24'h440000, 1'b0);
        sel();
        send_cmd(5'd13, 1'b1, 1'b0);
        shift_bits(8'hFF, 5, dummy);
        desel();
        rd(5'd13, 1, 24'h440000, "R11 partial byte not written", 1'b0);

        // R9: half-duplex wiring
        half_mode = 1'b1;
        wr(5'd14, 1, 24'h5A0000, 1'b0);
        rd(5'd14, 1, 24'h5A0000, "R9 read on shared line", 1'b0);
        rd(5'd7, 2, 24'h717200, "R9 burst read on shared line", 1'b0);
        half_mode = 1'b0;

        tick(20);
        if (exp_q.size() != 0) chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule